// File: doc/BRIEF.md
# Receive FIFO with Per-Character Error Flags

This block buffers characters coming out of a serial receiver and keeps three error flags with every character: a break flag, a framing-error flag and a parity flag. In multi-drop use, the parity flag carries the received address/data marker instead of a parity result. A single staging register sits behind the FIFO. When the FIFO is full, one extra character can wait there. A further character that arrives while that register is occupied is lost and raises a sticky overrun flag.

The CPU side pops characters with a read strobe. The popped character appears on `rd_data` one cycle later. The status outputs either show the flags of the character now at the head of the FIFO, or (in block mode) the OR of the flags of every character written since the last clear. Receive-ready and FIFO-full indications are produced from the occupancy.

Top module: `rx_status_fifo`

## Requirements
- R1: After reset the FIFO is empty, `rx_ready`, `fifo_full`, `ovr_err` and all three status outputs are 0, and `rd_data` is 0.
- R2: A push into a non-full FIFO is stored. `rx_ready` is 1 in the next cycle. Characters leave in arrival order, and a read places the popped character on `rd_data` in the cycle after the read.
- R3: With `blk_mode`=0, `st_brk`, `st_ferr` and `st_perr` show the flags stored with the head character. They change when that character is popped, and they are 0 while the FIFO is empty.
- R4: With `blk_mode`=1, the status outputs show the bitwise OR of the flags of all characters written into the FIFO since the last clear. Popping characters leaves them unchanged.
- R5: `err_clr` clears the accumulated flags and `ovr_err`. A character written in the same cycle contributes its flags after the clear, and a loss in that cycle sets `ovr_err` again.
- R6: `fifo_full` is 1 exactly when all DEPTH entries are occupied. A push into a full FIFO with the staging register free is kept in the staging register, without overrun.
- R7: A read while the staging register holds a character moves that character into the FIFO in the same cycle. `fifo_full` stays 1, and the staged character comes out after the ones already in the FIFO.
- R8: A push while the FIFO is full, the staging register is occupied and no read occurs is discarded together with its flags, and `ovr_err` becomes 1 and stays 1.
- R9: A push in the same cycle as a read, while the staging register is occupied, is not lost. The staged character enters the FIFO and the new one takes the staging register.
- R10: `rx_ready` falls only when a read leaves the FIFO empty. A read of an empty FIFO leaves `rd_data` and all flags unchanged.
- R11: `rx_rst` empties the FIFO and the staging register and clears `ovr_err` and the accumulated flags. `rd_data` is kept.
- R12: The parity slot is stored verbatim, so an address/data marker on `rx_perr` comes out unchanged on `st_perr` with its character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_push | input | 1 | Receiver delivers a completed character |
| rx_data | input | DW | Delivered character |
| rx_brk | input | 1 | Break flag of the delivered character |
| rx_ferr | input | 1 | Framing-error flag of the delivered character |
| rx_perr | input | 1 | Parity-error flag, or address/data marker in multi-drop use |
| cpu_rd | input | 1 | CPU pops the head character |
| blk_mode | input | 1 | 0: per-character flags, 1: accumulated flags |
| err_clr | input | 1 | Clear accumulated flags and overrun |
| rx_rst | input | 1 | Receiver reset: flush contents and errors |
| rd_data | output | DW | Last popped character |
| st_brk | output | 1 | Break status |
| st_ferr | output | 1 | Framing status |
| st_perr | output | 1 | Parity or address/data status |
| ovr_err | output | 1 | Sticky overrun |
| rx_ready | output | 1 | FIFO holds at least one character |
| fifo_full | output | 1 | All entries occupied |

## Verification
The write of a new character and the CPU pop can fall in the same cycle. This case is sensitive when the FIFO is full and the staging register is occupied, because the freed slot, the staged character and the arriving character all move at once. The bench provokes it by filling DEPTH+1 characters and then issuing a push and a read together. It also provokes it throughout a long pseudo-random phase. A queue model judges every cycle whether the staged character refilled the FIFO, whether the new character was staged rather than dropped, and whether `fifo_full` and `ovr_err` stayed correct.

// File: rtl/rxsf_pkg.sv
package rxsf_pkg;
  localparam int FLAG_W = 3;

  typedef struct packed {
    logic brk;
    logic ferr;
    logic perr;
  } rxsf_flags_t;
endpackage

// File: rtl/rxsf_store.sv
module rxsf_store #(
  parameter int DEPTH = 16,
  parameter int EW    = 11,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          wr,
  input  logic [EW-1:0] wdata,
  input  logic          rd,
  output logic [EW-1:0] head,
  output logic [CW-1:0] count
);
  logic [EW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  function automatic logic [CW-1:0] next_cnt(input logic [CW-1:0] c, input logic w, input logic r);
    return c + CW'(w) - CW'(r);
  endfunction

  always_ff @(posedge clk) begin
    if (wr && !clear) mem[wptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else if (clear) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (wr) wptr <= bump(wptr);
      if (rd) rptr <= bump(rptr);
      count <= next_cnt(count, wr, rd);
    end
  end

  assign head = mem[rptr];

  p_count_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  p_write_has_room_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && count == CW'(DEPTH)) |-> rd);
  p_read_nonempty_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd |-> (count != '0));
endmodule

// File: rtl/rxsf_stage.sv
module rxsf_stage #(
  parameter int EW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          push,
  input  logic [EW-1:0] push_ent,
  input  logic          full,
  input  logic          rd_fire,
  output logic          wr_fire,
  output logic [EW-1:0] wr_ent,
  output logic          lost,
  output logic          hold_valid
);
  logic [EW-1:0] hold_ent;
  logic          hold_v_n;
  logic [EW-1:0] hold_ent_n;
  logic          room;

  assign room = !full || rd_fire;

  always_comb begin
    wr_fire    = 1'b0;
    wr_ent     = push_ent;
    lost       = 1'b0;
    hold_v_n   = hold_valid;
    hold_ent_n = hold_ent;
    if (clear) begin
      hold_v_n = 1'b0;
    end else if (hold_valid) begin
      wr_ent = hold_ent;
      if (room) begin
        wr_fire    = 1'b1;
        hold_v_n   = push;
        hold_ent_n = push_ent;
      end else begin
        lost = push;
      end
    end else if (push) begin
      if (room) begin
        wr_fire = 1'b1;
      end else begin
        hold_v_n   = 1'b1;
        hold_ent_n = push_ent;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_valid <= 1'b0;
      hold_ent   <= '0;
    end else begin
      hold_valid <= hold_v_n;
      hold_ent   <= hold_ent_n;
    end
  end

  p_hold_behind_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hold_valid |-> full);
  p_lost_keeps_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    lost |=> hold_valid);
endmodule

// File: rtl/rxsf_errs.sv
module rxsf_errs
  import rxsf_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clear,
  input  logic        clr_err,
  input  logic        wr_fire,
  input  rxsf_flags_t wr_flags,
  input  logic        lost,
  output rxsf_flags_t acc,
  output logic        ovr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc <= '0;
      ovr <= 1'b0;
    end else if (clear) begin
      acc <= '0;
      ovr <= 1'b0;
    end else begin
      acc <= (clr_err ? rxsf_flags_t'('0) : acc) | (wr_fire ? wr_flags : rxsf_flags_t'('0));
      ovr <= (clr_err ? 1'b0 : ovr) | lost;
    end
  end

  p_ovr_on_loss_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (lost && !clear) |=> ovr);
  p_ovr_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr && !clr_err && !clear) |=> ovr);
  p_brk_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc.brk && !clr_err && !clear) |=> acc.brk);
endmodule

// File: rtl/rx_status_fifo.sv
module rx_status_fifo
  import rxsf_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_push,
  input  logic [DW-1:0] rx_data,
  input  logic          rx_brk,
  input  logic          rx_ferr,
  input  logic          rx_perr,
  input  logic          cpu_rd,
  input  logic          blk_mode,
  input  logic          err_clr,
  input  logic          rx_rst,
  output logic [DW-1:0] rd_data,
  output logic          st_brk,
  output logic          st_ferr,
  output logic          st_perr,
  output logic          ovr_err,
  output logic          rx_ready,
  output logic          fifo_full
);
  localparam int EW = DW + FLAG_W;
  localparam int CW = $clog2(DEPTH + 1);

  logic [EW-1:0] push_ent, wr_ent, head;
  logic [CW-1:0] count;
  logic          rd_fire, wr_fire, lost, hold_valid;
  rxsf_flags_t   head_flags, acc, shown;

  assign push_ent  = {rx_brk, rx_ferr, rx_perr, rx_data};
  assign rx_ready  = (count != '0);
  assign fifo_full = (count == CW'(DEPTH));
  assign rd_fire   = cpu_rd && rx_ready && !rx_rst;

  rxsf_stage #(.EW(EW)) u_stage (
    .clk(clk), .rst_n(rst_n), .clear(rx_rst), .push(rx_push), .push_ent(push_ent),
    .full(fifo_full), .rd_fire(rd_fire), .wr_fire(wr_fire), .wr_ent(wr_ent),
    .lost(lost), .hold_valid(hold_valid)
  );

  rxsf_store #(.DEPTH(DEPTH), .EW(EW)) u_store (
    .clk(clk), .rst_n(rst_n), .clear(rx_rst), .wr(wr_fire), .wdata(wr_ent),
    .rd(rd_fire), .head(head), .count(count)
  );

  rxsf_errs u_errs (
    .clk(clk), .rst_n(rst_n), .clear(rx_rst), .clr_err(err_clr), .wr_fire(wr_fire),
    .wr_flags(rxsf_flags_t'(wr_ent[EW-1:DW])), .lost(lost), .acc(acc), .ovr(ovr_err)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rd_data <= '0;
    else if (rd_fire) rd_data <= head[DW-1:0];
  end

  assign head_flags = rxsf_flags_t'(head[EW-1:DW]);
  assign shown      = blk_mode ? acc : (rx_ready ? head_flags : rxsf_flags_t'('0));
  assign st_brk     = shown.brk;
  assign st_ferr    = shown.ferr;
  assign st_perr    = shown.perr;

  p_ready_after_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && !rx_rst) |=> rx_ready);
  p_refill_stays_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_full && rd_fire && hold_valid) |=> fifo_full);
  p_ready_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_ready && !cpu_rd && !rx_rst) |=> rx_ready);
  p_flush_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rx_rst |=> (!rx_ready && !ovr_err && !hold_valid));
endmodule

// File: tb/rx_status_fifo_test.sv
`timescale 1ns/100ps
module rx_status_fifo_test;
  localparam int DEPTH = 16;
  localparam int DW    = 8;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst_n, rx_push, rx_brk, rx_ferr, rx_perr, cpu_rd, blk_mode, err_clr, rx_rst;
  logic [DW-1:0] rx_data, rd_data;
  logic          st_brk, st_ferr, st_perr, ovr_err, rx_ready, fifo_full;

  rx_status_fifo #(.DEPTH(DEPTH), .DW(DW)) uut (.*);

  int    checks = 0, errors = 0;
  string tag = "R1";
  bit    done = 1'b0;

  logic [10:0] mq[$];
  bit          hv = 1'b0;
  logic [10:0] he;
  bit          m_ovr = 1'b0;
  logic [2:0]  m_acc = '0;
  logic [7:0]  m_last = '0;
  bit          mode_b = 1'b0;

  task automatic chk(input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic compare();
    logic [2:0] es;
    es = blk_mode ? m_acc : ((mq.size() > 0) ? mq[0][10:8] : 3'b000);
    chk("rx_ready",  {7'd0, rx_ready},  {7'd0, mq.size() > 0});
    chk("fifo_full", {7'd0, fifo_full}, {7'd0, mq.size() == DEPTH});
    chk("ovr_err",   {7'd0, ovr_err},   {7'd0, m_ovr});
    chk("status",    {5'd0, st_brk, st_ferr, st_perr}, {5'd0, es});
    chk("rd_data",   rd_data, m_last);
  endtask

  task automatic model_step(input bit p, input logic [7:0] d, input logic [2:0] f,
                            input bit r, input bit clr, input bit rr);
    logic [10:0] ent;
    ent = {f, d};
    if (rr) begin
      mq.delete(); hv = 1'b0; m_ovr = 1'b0; m_acc = '0;
    end else begin
      if (clr) begin m_ovr = 1'b0; m_acc = '0; end
      if (r && mq.size() > 0) begin m_last = mq[0][7:0]; void'(mq.pop_front()); end
      if (hv && mq.size() < DEPTH) begin mq.push_back(he); m_acc |= he[10:8]; hv = 1'b0; end
      if (p) begin
        if (!hv && mq.size() < DEPTH) begin mq.push_back(ent); m_acc |= f; end
        else if (!hv) begin hv = 1'b1; he = ent; end
        else m_ovr = 1'b1;
      end
    end
  endtask

  task automatic cyc(input bit p, input logic [7:0] d, input logic [2:0] f,
                     input bit r, input bit clr, input bit rr);
    @(negedge clk);
    compare();
    rx_push = p; rx_data = d; {rx_brk, rx_ferr, rx_perr} = f;
    cpu_rd = r; err_clr = clr; rx_rst = rr; blk_mode = mode_b;
    model_step(p, d, f, r, clr, rr);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 8'h00, 3'b000, 0, 0, 0);
  endtask

  initial begin
    #(5 * 100000);
    if (!done) begin
      done = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    rst_n = 1'b0; rx_push = 0; rx_data = 0; rx_brk = 0; rx_ferr = 0; rx_perr = 0;
    cpu_rd = 0; blk_mode = 0; err_clr = 0; rx_rst = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    tag = "R1 reset";             idle(3);
    tag = "R2 order";
    cyc(1, 8'hA1, 3'b000, 0, 0, 0); cyc(1, 8'hA2, 3'b000, 0, 0, 0); cyc(1, 8'hA3, 3'b000, 0, 0, 0);
    for (int i = 0; i < 3; i++) cyc(0, 8'h00, 3'b000, 1, 0, 0);
    idle(2);
    tag = "R12 addr bit";
    cyc(1, 8'h55, 3'b001, 0, 0, 0); idle(1); cyc(0, 8'h00, 3'b000, 1, 0, 0); idle(1);
    tag = "R3 char mode";
    cyc(1, 8'h10, 3'b100, 0, 0, 0); cyc(1, 8'h11, 3'b010, 0, 0, 0); cyc(1, 8'h12, 3'b001, 0, 0, 0);
    for (int i = 0; i < 3; i++) begin idle(1); cyc(0, 8'h00, 3'b000, 1, 0, 0); end
    idle(2);
    tag = "R4 block mode"; mode_b = 1'b1;
    cyc(1, 8'h20, 3'b100, 0, 0, 0); cyc(1, 8'h21, 3'b010, 0, 0, 0);
    cyc(0, 8'h00, 3'b000, 1, 0, 0); cyc(0, 8'h00, 3'b000, 1, 0, 0); idle(3);
    tag = "R5 clear";
    cyc(1, 8'h30, 3'b001, 0, 1, 0); idle(2); cyc(0, 8'h00, 3'b000, 1, 1, 0); idle(2);
    tag = "R6 fill"; mode_b = 1'b0;
    for (int i = 0; i <= DEPTH; i++) cyc(1, 8'h40 + 8'(i), 3'(i), 0, 0, 0);
    idle(2);
    tag = "R7 refill";            cyc(0, 8'h00, 3'b000, 1, 0, 0); idle(2);
    tag = "R8 overrun";
    cyc(1, 8'h60, 3'b010, 0, 0, 0); cyc(1, 8'h61, 3'b111, 0, 0, 0); idle(2);
    tag = "R9 push with read";    cyc(1, 8'h62, 3'b100, 1, 0, 0); idle(2);
    tag = "R5 clear overrun";     cyc(0, 8'h00, 3'b000, 0, 1, 0); idle(1);
    tag = "R10 drain";
    for (int i = 0; i < DEPTH + 4; i++) cyc(0, 8'h00, 3'b000, 1, 0, 0);
    idle(2);
    tag = "R11 flush";
    for (int i = 0; i < 5; i++) cyc(1, 8'h70 + 8'(i), 3'b110, 0, 0, 0);
    cyc(1, 8'h7F, 3'b111, 1, 0, 1); idle(2);
    tag = "R9 mix";
    lfsr = 16'hACE1;
    for (int i = 0; i < 3000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (i % 200 == 0) mode_b = ~mode_b;
      cyc(lfsr[1:0] != 2'b00 || i < 1500 ? lfsr[2] | lfsr[3] : lfsr[2] & lfsr[3],
          lfsr[11:4], lfsr[14:12],
          (i < 1500) ? (lfsr[5:3] == 3'b000) : lfsr[6],
          lfsr[15:10] == 6'd0, lfsr[15:7] == 9'd0);
    end
    @(negedge clk);
    compare();
    if (!done) begin
      done = 1'b1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule